// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Engine

This block acts as a byte-addressed memory target on a two-wire serial bus. It runs on a system clock that oversamples the bus clock and data lines. It recognises start, repeated-start and stop conditions and decodes the select byte against a device-type nibble and three address pins. For writes it takes a two-byte memory address and then data bytes. It serves current-address reads, random reads and sequential reads. The data line is driven only through an open-drain enable.

The memory itself lives outside the block. Reads use a synchronous byte port: a one-cycle `rd_en` with `rd_addr`, and `rd_data` valid on the following cycle. Accepted write bytes go to a page-write controller over a valid/ready port. A byte is offered with `wreq_valid` and holds address and data stable until `wreq_ready` is seen high. The controller must accept each byte before the next one finishes, which is at least nine bus clocks later. The controller programs its buffered bytes on a `wcommit` pulse and throws them away on a `wdrop` pulse.

The system clock must run at least eight times faster than the bus clock.

Top module: `serial_mem_slave`

## Requirements
- R1: A falling data line while the synchronized clock line is high is a start condition. It restarts select-byte reception from any state, including the middle of a byte. A rising data line while the clock is high is a stop condition, which returns the block to idle with the data line released.
- R2: The select byte is received MSB first. It matches when bits [7:4] equal 4'b1010 and bits [3:1] equal `chip_sel`. Bit 0 selects read (1) or write (0). On a match the block pulls the data line low during the 9th clock.
- R3: On a select mismatch no acknowledge is given, and every later byte is ignored until the next start condition.
- R4: A write select is followed by two address bytes, high byte first, and each is acknowledged. The low ADDR_W bits of the 16-bit value are loaded into the address counter.
- R5: With `wr_lock` low, each write data byte is acknowledged and offered on the write port with the current counter value. Offered bytes hold `wreq_valid`, address and data until `wreq_ready` is high. After each byte only the low PAGE_W counter bits increment, wrapping inside the page.
- R6: With `wr_lock` high when a data byte completes, that byte is not acknowledged and is not offered, and the memory keeps its contents. Select and address bytes are still acknowledged.
- R7: A stop in the clock slot right after a data-byte acknowledge pulses `wcommit` once if any byte was offered. A start or stop anywhere else after offered bytes pulses `wdrop`, and the memory stays unchanged.
- R8: A read select without a preceding address returns the byte at the counter, and the counter then increments.
- R9: A random read, meaning a write select and two address bytes followed by a repeated start and a read select, returns the byte at the loaded address.
- R10: A master acknowledge after a read byte makes the block send the next consecutive byte. A master no-acknowledge releases the line and returns the block to idle, so later clocks without a start get no acknowledge.
- R11: The read counter wraps from the last array address to 0.
- R12: Reads ignore `wr_lock`.
- R13: `sda_oe` is low out of reset, low in idle and after a stop, and is asserted only while the synchronized clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Open-drain pull-down enable for the data line |
| chip_sel | input | 3 | Address pins compared with select bits [3:1] |
| wr_lock | input | 1 | High blocks data writes |
| rd_en | output | 1 | One-cycle memory read strobe |
| rd_addr | output | ADDR_W | Memory read address |
| rd_data | input | 8 | Read data, valid the cycle after `rd_en` |
| wreq_valid | output | 1 | Write byte offered |
| wreq_ready | input | 1 | Controller accepts the offered byte |
| wreq_addr | output | ADDR_W | Address of the offered byte |
| wreq_data | output | 8 | Offered data byte |
| wcommit | output | 1 | Pulse: program the buffered bytes |
| wdrop | output | 1 | Pulse: discard the buffered bytes |

## Verification
The bench sweeps all 64 combinations of select-address bits and pin values. A design that compared the wrong bits would acknowledge another target's traffic. A page write that crosses the end of a page is read back. Incrementing the full counter there would spill bytes into the next page. A sequential read runs across the top of the array, where an unwrapped counter would return the wrong bytes after the last address. A stop placed off the acknowledge slot and a repeated start after data must both leave memory untouched; committing on them would corrupt memory. A start inside a byte must realign reception, or every later byte would be shifted.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SEL,
    PH_AHI,
    PH_ALO,
    PH_WR,
    PH_RD
  } phase_t;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_s,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-1:0], line_in};
  end

  assign line_s = chain[STAGES-1];
  assign rise   = chain[STAGES-1] & ~chain[STAGES];
  assign fall   = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/twi_addr_ctr.sv
module twi_addr_ctr #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step_seq,
  input  logic              step_page,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] page_next;

  generate
    if (PAGE_W < ADDR_W) begin : g_page
      assign page_next = {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + PAGE_W'(1)};
    end else begin : g_flat
      assign page_next = addr + ADDR_W'(1);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         addr <= '0;
    else if (load)      addr <= load_val;
    else if (step_seq)  addr <= addr + ADDR_W'(1);
    else if (step_page) addr <= page_next;
  end
endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave
  import twi_mem_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int PAGE_W   = 5,
  parameter int SYNC_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  input  logic [2:0]        chip_sel,
  input  logic              wr_lock,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              wreq_valid,
  input  logic              wreq_ready,
  output logic [ADDR_W-1:0] wreq_addr,
  output logic [7:0]        wreq_data,
  output logic              wcommit,
  output logic              wdrop
);
  localparam int NLINES = 2;

  // line 0 = clock, line 1 = data
  logic [NLINES-1:0] raw, lvl, ris, fal;
  assign raw = {sda_in, scl_in};

  genvar gi;
  generate
    for (gi = 0; gi < NLINES; gi++) begin : g_sync
      twi_line_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_in(raw[gi]),
        .line_s (lvl[gi]),
        .rise   (ris[gi]),
        .fall   (fal[gi])
      );
    end
  endgenerate

  logic scl_s, sda_s, scl_rise, scl_fall;
  logic start_ev, stop_ev;
  assign scl_s    = lvl[0];
  assign sda_s    = lvl[1];
  assign scl_rise = ris[0];
  assign scl_fall = fal[0];
  assign start_ev = scl_s & fal[1];
  assign stop_ev  = scl_s & ris[1];

  phase_t            phase, nxt_phase;
  logic [3:0]        bitcnt;
  logic              in_ack;
  logic [7:0]        shreg, txreg, addr_hi;
  logic              oe_r, fetch_q, load_q, wrote;
  logic              wv_r, commit_r, drop_r;
  logic [ADDR_W-1:0] wa_r, ctr_addr, ctr_load_val;
  logic [7:0]        wd_r;

  logic rx_done, sel_match, rd_ack_rise, fetch;
  logic ctr_load, ctr_seq, ctr_page;

  always_comb begin
    rx_done      = scl_fall && (bitcnt == 4'd8) && !in_ack &&
                   (phase inside {PH_SEL, PH_AHI, PH_ALO, PH_WR});
    sel_match    = (shreg[7:4] == DEV_TYPE) && (shreg[3:1] == chip_sel);
    rd_ack_rise  = scl_rise && in_ack && (phase == PH_RD);
    ctr_load     = !start_ev && !stop_ev && rx_done && (phase == PH_ALO);
    ctr_load_val = ADDR_W'({addr_hi, shreg});
    ctr_page     = !start_ev && !stop_ev && rx_done && (phase == PH_WR) && !wr_lock;
    ctr_seq      = !start_ev && !stop_ev && rd_ack_rise;
    fetch        = !start_ev && !stop_ev &&
                   ((rx_done && (phase == PH_SEL) && sel_match && shreg[0]) ||
                    (rd_ack_rise && !sda_s));
  end

  twi_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ctr_load),
    .load_val (ctr_load_val),
    .step_seq (ctr_seq),
    .step_page(ctr_page),
    .addr     (ctr_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      nxt_phase <= PH_IDLE;
      bitcnt    <= '0;
      in_ack    <= 1'b0;
      shreg     <= '0;
      txreg     <= '0;
      addr_hi   <= '0;
      oe_r      <= 1'b0;
      fetch_q   <= 1'b0;
      load_q    <= 1'b0;
      wrote     <= 1'b0;
      wv_r      <= 1'b0;
      wa_r      <= '0;
      wd_r      <= '0;
      commit_r  <= 1'b0;
      drop_r    <= 1'b0;
    end else begin
      commit_r <= 1'b0;
      drop_r   <= 1'b0;
      fetch_q  <= fetch;
      load_q   <= fetch_q;
      if (load_q) txreg <= rd_data;
      if (wv_r && wreq_ready) wv_r <= 1'b0;

      if (start_ev) begin
        phase  <= PH_SEL;
        bitcnt <= '0;
        in_ack <= 1'b0;
        oe_r   <= 1'b0;
        if (wrote) drop_r <= 1'b1;
        wrote  <= 1'b0;
      end else if (stop_ev) begin
        phase  <= PH_IDLE;
        bitcnt <= '0;
        in_ack <= 1'b0;
        oe_r   <= 1'b0;
        if (wrote) begin
          if (phase == PH_WR && bitcnt == 4'd1 && !in_ack) commit_r <= 1'b1;
          else                                             drop_r   <= 1'b1;
        end
        wrote  <= 1'b0;
      end else if (phase != PH_IDLE) begin
        if (scl_rise) begin
          if (in_ack) begin
            if (phase == PH_RD && sda_s) begin
              phase  <= PH_IDLE;
              in_ack <= 1'b0;
            end
          end else if (bitcnt < 4'd8) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end
        end
        if (scl_fall) begin
          if (in_ack) begin
            in_ack <= 1'b0;
            bitcnt <= '0;
            phase  <= nxt_phase;
            oe_r   <= (nxt_phase == PH_RD) ? ~txreg[7] : 1'b0;
          end else if (bitcnt == 4'd8) begin
            case (phase)
              PH_SEL: begin
                if (sel_match) begin
                  oe_r      <= 1'b1;
                  in_ack    <= 1'b1;
                  nxt_phase <= shreg[0] ? PH_RD : PH_AHI;
                end else begin
                  phase <= PH_IDLE;
                end
              end
              PH_AHI: begin
                addr_hi   <= shreg;
                oe_r      <= 1'b1;
                in_ack    <= 1'b1;
                nxt_phase <= PH_ALO;
              end
              PH_ALO: begin
                oe_r      <= 1'b1;
                in_ack    <= 1'b1;
                nxt_phase <= PH_WR;
              end
              PH_WR: begin
                in_ack    <= 1'b1;
                nxt_phase <= PH_WR;
                if (!wr_lock) begin
                  oe_r  <= 1'b1;
                  wv_r  <= 1'b1;
                  wa_r  <= ctr_addr;
                  wd_r  <= shreg;
                  wrote <= 1'b1;
                end else begin
                  oe_r <= 1'b0;
                end
              end
              PH_RD: begin
                oe_r      <= 1'b0;
                in_ack    <= 1'b1;
                nxt_phase <= PH_RD;
              end
              default: phase <= PH_IDLE;
            endcase
          end else if (phase == PH_RD && bitcnt != 4'd0) begin
            oe_r <= ~txreg[3'd7 - bitcnt[2:0]];
          end
        end
      end
    end
  end

  assign sda_oe     = oe_r;
  assign rd_en      = fetch_q;
  assign rd_addr    = ctr_addr;
  assign wreq_valid = wv_r;
  assign wreq_addr  = wa_r;
  assign wreq_data  = wd_r;
  assign wcommit    = commit_r;
  assign wdrop      = drop_r;
endmodule

// File: rtl/serial_mem_slave_chk.sv
module serial_mem_slave_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              stop_ev,
  input logic              sda_oe,
  input logic              wr_lock,
  input logic              rd_en,
  input logic              wreq_valid,
  input logic              wreq_ready,
  input logic [ADDR_W-1:0] wreq_addr,
  input logic [7:0]        wreq_data
);
  // R13
  oe_low_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R1
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);

  // R5
  wreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wreq_valid && !wreq_ready) |=> (wreq_valid && $stable(wreq_addr) && $stable(wreq_data)));

  // R6
  lock_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wreq_valid) |-> !$past(wr_lock));

  // R8
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en);
endmodule

bind serial_mem_slave serial_mem_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_s      (scl_s),
  .stop_ev    (stop_ev),
  .sda_oe     (sda_oe),
  .wr_lock    (wr_lock),
  .rd_en      (rd_en),
  .wreq_valid (wreq_valid),
  .wreq_ready (wreq_ready),
  .wreq_addr  (wreq_addr),
  .wreq_data  (wreq_data)
);

// File: tb/sim_serial_mem_slave.sv
module sim_serial_mem_slave;
  localparam int AW = 8;
  localparam int PW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [2:0] csel = 3'd5;
  logic lock = 1'b0;
  logic rd_en;
  logic [AW-1:0] rd_addr;
  logic [7:0] rd_data;
  logic wv, wr_rdy, wc, wdp;
  logic [AW-1:0] wa;
  logic [7:0] wd;
  wire sda_line = sda_m & ~sda_oe;

  int n_chk = 0, n_bad = 0, commits = 0, drops = 0, cyc = 0, pn = 0;
  logic stall = 1'b0;
  logic [7:0] mem [256];
  logic [AW-1:0] pa [32];
  logic [7:0] pdv [32];
  logic [7:0] rbuf [8];

  assign wr_rdy = stall ? ((cyc % 3) == 0) : 1'b1;

  function automatic logic [7:0] f(input int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  serial_mem_slave #(.ADDR_W(AW), .PAGE_W(PW), .SYNC_LEN(2)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
    .chip_sel(csel), .wr_lock(lock), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wreq_valid(wv), .wreq_ready(wr_rdy), .wreq_addr(wa), .wreq_data(wd),
    .wcommit(wc), .wdrop(wdp)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= f(i);
      pn <= 0;
    end else begin
      if (rd_en) rd_data <= mem[rd_addr];
      if (wv && wr_rdy) begin
        if (pn < 32) begin
          pa[pn]  <= wa;
          pdv[pn] <= wd;
        end
        pn <= pn + 1;
      end
      if (wc) begin
        for (int i = 0; i < 32; i++) if (i < pn) mem[pa[i]] <= pdv[i];
        pn <= 0;
        commits <= commits + 1;
      end
      if (wdp) begin
        pn <= 0;
        drops <= drops + 1;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic q();
    repeat (4) @(negedge clk);
  endtask

  task automatic bstart();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic bstop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q(); q();
  endtask

  task automatic sbit(input logic b);
    sda_m = b; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
  endtask

  task automatic sbyte(input logic [7:0] b, output int ack);
    for (int i = 7; i >= 0; i--) sbit(b[i]);
    sda_m = 1'b1; q(); scl_m = 1'b1; q();
    ack = (sda_line == 1'b0) ? 1 : 0;
    q(); scl_m = 1'b0; q();
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q(); scl_m = 1'b1; q(); b[i] = sda_line; q(); scl_m = 1'b0;
    end
    q(); sda_m = ~mack; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q(); sda_m = 1'b1;
  endtask

  function automatic logic [7:0] sel(input logic rw);
    return {4'b1010, csel, rw};
  endfunction

  // write preamble: select + two address bytes, checks the three acks
  task automatic wr_head(input logic [7:0] hi, input logic [7:0] lo);
    int ak;
    bstart();
    sbyte(sel(1'b0), ak); chk("R2 write select ack", ak, 1);
    sbyte(hi, ak);        chk("R4 address high ack", ak, 1);
    sbyte(lo, ak);        chk("R4 address low ack", ak, 1);
  endtask

  task automatic rd_rand(input logic [7:0] a, input int n);
    int ak;
    wr_head(8'h12, a);
    bstart();
    sbyte(sel(1'b1), ak); chk("R9 read select ack", ak, 1);
    for (int k = 0; k < n; k++) rbyte(k < n - 1, rbuf[k]);
    bstop();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    int ak, c0, d0;
    logic [7:0] b;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R13 reset sda_oe", int'(sda_oe), 0);
    chk("R5 reset wreq_valid", int'(wv), 0);

    // R2 / R3 sweep of select address bits against pins
    for (int p = 0; p < 8; p++) begin
      for (int s = 0; s < 8; s++) begin
        csel = 3'(p);
        bstart();
        sbyte({4'b1010, 3'(s), 1'b0}, ak);
        chk((s == p) ? "R2 select match ack" : "R3 select mismatch", ak, (s == p) ? 1 : 0);
        if (s != p) begin
          sbyte(8'h00, ak);
          chk("R3 ignored after mismatch", ak, 0);
        end
        bstop();
      end
    end
    csel = 3'd5;
    chk("R13 idle release", int'(sda_oe), 0);

    // R3 wrong device type
    bstart(); sbyte({4'b1011, csel, 1'b0}, ak); chk("R3 wrong type", ak, 0); bstop();

    // single byte write then random read
    c0 = commits;
    wr_head(8'h12, 8'h40);
    sbyte(8'hA5, ak); chk("R5 data ack", ak, 1);
    bstop();
    repeat (4) @(negedge clk);
    chk("R7 commit count", commits, c0 + 1);
    chk("R13 released after stop", int'(sda_oe), 0);
    rd_rand(8'h40, 1);
    chk("R9 random read data", rbuf[0], 8'hA5);

    // R8 current address reads
    bstart(); sbyte(sel(1'b1), ak); chk("R8 current select ack", ak, 1);
    rbyte(1'b0, b); bstop(); chk("R8 current read 0x41", b, f(8'h41));
    bstart(); sbyte(sel(1'b1), ak); rbyte(1'b0, b); bstop();
    chk("R8 current read 0x42", b, f(8'h42));

    // R5 page write across page end with back-pressure
    stall = 1'b1;
    wr_head(8'h00, 8'h1E);
    for (int k = 0; k < 4; k++) begin
      sbyte(8'(8'h11 * (k + 1)), ak); chk("R5 page data ack", ak, 1);
    end
    bstop();
    stall = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7 page commit", commits, c0 + 2);
    rd_rand(8'h1E, 3);
    chk("R5 page byte 0x1E", rbuf[0], 8'h11);
    chk("R5 page byte 0x1F", rbuf[1], 8'h22);
    chk("R5 next page untouched", rbuf[2], f(8'h20));
    rd_rand(8'h00, 2);
    chk("R5 page wrap 0x00", rbuf[0], 8'h33);
    chk("R5 page wrap 0x01", rbuf[1], 8'h44);

    // R6 write lock, R12 reads unaffected
    lock = 1'b1;
    c0 = commits;
    wr_head(8'h00, 8'h50);
    sbyte(8'h99, ak); chk("R6 locked data nack", ak, 0);
    sbyte(8'h98, ak); chk("R6 locked data nack 2", ak, 0);
    bstop();
    repeat (4) @(negedge clk);
    chk("R6 no commit", commits, c0);
    rd_rand(8'h50, 2);
    chk("R12 read under lock", rbuf[0], f(8'h50));
    chk("R12 sequential under lock", rbuf[1], f(8'h51));
    lock = 1'b0;

    // R10 / R11 sequential read over top of array
    rd_rand(8'hFD, 5);
    chk("R11 byte 0xFD", rbuf[0], f(8'hFD));
    chk("R10 byte 0xFE", rbuf[1], f(8'hFE));
    chk("R10 byte 0xFF", rbuf[2], f(8'hFF));
    chk("R11 wrap to 0x00", rbuf[3], 8'h33);
    chk("R11 byte 0x01", rbuf[4], 8'h44);
    bstart(); sbyte(sel(1'b1), ak); rbyte(1'b0, b);
    chk("R10 nack releases", int'(sda_oe), 0);
    sbyte(8'hA0, ak); chk("R10 idle after nack", ak, 0);
    bstop();

    // R7 repeated start after data drops the write
    d0 = drops;
    wr_head(8'h00, 8'h60);
    sbyte(8'h77, ak);
    bstart(); bstop();
    repeat (4) @(negedge clk);
    chk("R7 drop on restart", drops, d0 + 1);
    rd_rand(8'h60, 1);
    chk("R7 memory kept on restart", rbuf[0], f(8'h60));

    // R7 stop off the slot
    wr_head(8'h00, 8'h61);
    sbyte(8'h55, ak);
    sbit(1'b1); sbit(1'b0); sbit(1'b1);
    bstop();
    repeat (4) @(negedge clk);
    chk("R7 drop on late stop", drops, d0 + 2);
    rd_rand(8'h61, 1);
    chk("R7 memory kept on late stop", rbuf[0], f(8'h61));

    // R1 start in the middle of a byte
    c0 = commits;
    bstart(); sbit(1'b1); sbit(1'b0); sbit(1'b1);
    bstart();
    sbyte(sel(1'b0), ak); chk("R1 restart select ack", ak, 1);
    sbyte(8'h00, ak); sbyte(8'h70, ak);
    sbyte(8'h5A, ak); chk("R1 data ack after restart", ak, 1);
    bstop();
    repeat (4) @(negedge clk);
    chk("R1 commit after restart", commits, c0 + 1);
    rd_rand(8'h70, 1);
    chk("R1 data after restart", rbuf[0], 8'h5A);

    summary();
    $finish;
  end
endmodule